// File: doc/BRIEF.md
# Subroutine Call Target and Return Push Unit

This block carries out the control-transfer part of a subroutine call in a segmented processor core. When started, it takes the call form, the operand size, the address of the instruction after the call, the displacement or absolute offset, the far selector and the current code selector, instruction pointer and stack pointer. From these it works out the new code selector and instruction pointer and issues the stack writes that save the return address. It then reports the new stack pointer. Before anything is written, it checks the target against the code segment limit and checks the whole push against the lowest writable stack address.

There are four call forms. A relative near call adds a displacement to the next-instruction address. An absolute near call jumps to a given offset. A direct far call and an indirect far call both load a selector and an offset. For the indirect form, the offset and selector have already been fetched by the caller, so the unit treats both far forms the same way. With 16-bit operand size, every target and every pushed offset is cut to 16 bits, and each push is 2 bytes. With 32-bit size, each push is 4 bytes, and a pushed selector is zero-extended to 32 bits.

If either check fails, the unit raises a fault flag. In that case it makes no stack writes, and the selector, instruction pointer and stack pointer outputs take the unchanged current values. Descriptor lookups and privilege rules belong to other logic.

Top module: `call_push_unit`

## Requirements
- R1: A relative near call (form code 2'b00) with 32-bit size targets nextIp + operand, modulo 2^32, with the operand taken as a two's-complement displacement.
- R2: With 16-bit size (opSize32 = 0), bits 31:16 of the new instruction pointer are zero for every form, and the pushed return offset is nextIp with bits 31:16 cleared.
- R3: Absolute near (2'b01) and far (2'b10 direct, 2'b11 indirect) calls target the operand. A far call loads farSel as the new selector. A near call leaves the selector at curCs.
- R4: A near call makes exactly one write: the return offset, at address curSp - S, where S is 2 for 16-bit size and 4 for 32-bit size. The new stack pointer is then curSp - S.
- R5: A far call makes two writes in order. The first is the zero-extended curCs at curSp - S. The second is the return offset at curSp - 2S. The new stack pointer is curSp - 2S. wrWide is 1 on 4-byte writes and 0 on 2-byte writes.
- R6: gpFault is set when the target, after truncation, is greater than codeLimit. A target equal to codeLimit is legal.
- R7: ssFault is set when the push total T (S for near, 2S for far) does not fit: curSp < stackLow + T, computed without wrap-around.
- R8: When either fault is set, no write is issued, and newCs, newEip and newSp equal curCs, curEip and curSp.
- R9: done is a one-cycle pulse. It comes 2 cycles after the start edge on a fault, 3 cycles after for a near call, and 4 cycles after for a far call. Fault flags are cleared by the next accepted start.
- R10: A start pulse that arrives while an operation is in progress is ignored. It does not change that operation's results, and it does not launch a second operation.
- R11: After reset, done, wrEn, the fault flags and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle strobe that begins a call |
| callForm | input | 2 | 00 relative near, 01 absolute near, 10 direct far, 11 indirect far |
| opSize32 | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| nextIp | input | 32 | Address of the instruction after the call |
| operand | input | 32 | Displacement (relative) or target offset |
| farSel | input | 16 | Target selector for far calls |
| curCs | input | 16 | Current code selector |
| curEip | input | 32 | Current instruction pointer, kept on a fault |
| curSp | input | 32 | Current stack pointer |
| codeLimit | input | 32 | Highest legal code offset |
| stackLow | input | 32 | Lowest writable stack address |
| wrEn | output | 1 | Stack write request |
| wrAddr | output | 32 | Stack write address |
| wrData | output | 32 | Stack write data |
| wrWide | output | 1 | 1 = 4-byte write, 0 = 2-byte write |
| newCs | output | 16 | Resulting code selector |
| newEip | output | 32 | Resulting instruction pointer |
| newSp | output | 32 | Resulting stack pointer |
| gpFault | output | 1 | Code limit violation |
| ssFault | output | 1 | Stack bound violation |
| done | output | 1 | Completion pulse |

## Verification
A working stack pointer left at the wrong value shows up at once on the next write address. It also shows up on newSp when done arrives, so the far-call tests compare both writes one after the other. A wrong state step or a missed fault abort shows up as done arriving in the wrong cycle, or as a write during a faulting call; each test counts the cycles from start to done and records every write. A start that is wrongly taken while busy shows up as changed results or as extra writes after done. A window of idle cycles is watched after each call to catch this.

// File: rtl/call_unit_pkg.sv
package call_unit_pkg;
  localparam int ADDR_W = 32;
  localparam int SEL_W  = 16;

  typedef enum logic [1:0] {
    FORM_REL     = 2'b00,
    FORM_ABS     = 2'b01,
    FORM_FAR_DIR = 2'b10,
    FORM_FAR_IND = 2'b11
  } callForm_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'b00,
    ST_EVAL     = 2'b01,
    ST_PUSH_SEL = 2'b10,
    ST_PUSH_OFS = 2'b11
  } ctlState_e;

  typedef struct packed {
    logic capture;
    logic pushSel;
    logic pushOfs;
    logic commit;
    logic abortFault;
  } dpCtl_t;
endpackage

// File: rtl/call_datapath.sv
module call_datapath
  import call_unit_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [1:0]    callForm,
  input  logic          opSize32,
  input  logic [AW-1:0] nextIp,
  input  logic [AW-1:0] operand,
  input  logic [SW-1:0] farSel,
  input  logic [SW-1:0] curCs,
  input  logic [AW-1:0] curEip,
  input  logic [AW-1:0] curSp,
  input  logic [AW-1:0] codeLimit,
  input  logic [AW-1:0] stackLow,
  output logic          isFar,
  output logic          faultAny,
  output logic          wrEn,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] wrData,
  output logic          wrWide,
  output logic [SW-1:0] newCs,
  output logic [AW-1:0] newEip,
  output logic [AW-1:0] newSp,
  output logic          gpFault,
  output logic          ssFault
);
  localparam int HALF_W = AW / 2;
  localparam logic [AW-1:0] LOW_MASK = {{(AW-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [AW-1:0] NARROW_BYTES = AW'(2);
  localparam logic [AW-1:0] WIDE_BYTES   = AW'(4);

  callForm_e     formQ;
  logic          wideQ;
  logic [AW-1:0] nextIpQ, operandQ, eipQ, spQ, spOrigQ, codeLimQ, stackLowQ;
  logic [SW-1:0] selQ, csQ;

  logic [AW-1:0] sizeBytes, pushTotal, rawTarget, target, retOfs;
  logic          gpHit, ssHit;

  always_comb begin
    sizeBytes = wideQ ? WIDE_BYTES : NARROW_BYTES;
    isFar     = formQ[1];
    pushTotal = isFar ? (sizeBytes << 1) : sizeBytes;
    rawTarget = (formQ == FORM_REL) ? (nextIpQ + operandQ) : operandQ;
    target    = wideQ ? rawTarget : (rawTarget & LOW_MASK);
    retOfs    = wideQ ? nextIpQ : (nextIpQ & LOW_MASK);
    gpHit     = target > codeLimQ;
    ssHit     = {1'b0, spQ} < ({1'b0, stackLowQ} + {1'b0, pushTotal});
    faultAny  = gpHit || ssHit;
    wrEn      = ctl.pushSel || ctl.pushOfs;
    wrAddr    = spQ - sizeBytes;
    wrData    = ctl.pushSel ? AW'(csQ) : retOfs;
    wrWide    = wideQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      formQ     <= FORM_REL;
      wideQ     <= 1'b0;
      nextIpQ   <= '0;
      operandQ  <= '0;
      eipQ      <= '0;
      spQ       <= '0;
      spOrigQ   <= '0;
      codeLimQ  <= '0;
      stackLowQ <= '0;
      selQ      <= '0;
      csQ       <= '0;
      newCs     <= '0;
      newEip    <= '0;
      newSp     <= '0;
      gpFault   <= 1'b0;
      ssFault   <= 1'b0;
    end else begin
      if (ctl.capture) begin
        formQ     <= callForm_e'(callForm);
        wideQ     <= opSize32;
        nextIpQ   <= nextIp;
        operandQ  <= operand;
        eipQ      <= curEip;
        spQ       <= curSp;
        spOrigQ   <= curSp;
        codeLimQ  <= codeLimit;
        stackLowQ <= stackLow;
        selQ      <= farSel;
        csQ       <= curCs;
        gpFault   <= 1'b0;
        ssFault   <= 1'b0;
      end
      if (wrEn) spQ <= wrAddr;
      if (ctl.commit) begin
        newCs  <= isFar ? selQ : csQ;
        newEip <= target;
        newSp  <= wrAddr;
      end
      if (ctl.abortFault) begin
        gpFault <= gpHit;
        ssFault <= ssHit;
        newCs   <= csQ;
        newEip  <= eipQ;
        newSp   <= spOrigQ;
      end
    end
  end

  AST_FAULT_KEEPS_SP: assert property (@(posedge clk) disable iff (!rstN)
    (gpFault || ssFault) |-> (newSp == spOrigQ && newCs == csQ)); // R8

  AST_NARROW_EIP_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> (wideQ || newEip[AW-1:HALF_W] == '0)); // R2

  AST_SECOND_PUSH_BELOW_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pushOfs && $past(ctl.pushSel)) |-> (wrAddr == $past(wrAddr) - sizeBytes)); // R5

  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.abortFault |=> !wrEn); // R8
endmodule

// File: rtl/call_control.sv
module call_control
  import call_unit_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   isFar,
  input  logic   faultAny,
  output dpCtl_t ctl,
  output logic   done
);
  ctlState_e state, stateNxt;

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.capture = 1'b1;
          stateNxt    = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (faultAny) begin
          ctl.abortFault = 1'b1;
          stateNxt       = ST_IDLE;
        end else begin
          stateNxt = isFar ? ST_PUSH_SEL : ST_PUSH_OFS;
        end
      end
      ST_PUSH_SEL: begin
        ctl.pushSel = 1'b1;
        stateNxt    = ST_PUSH_OFS;
      end
      ST_PUSH_OFS: begin
        ctl.pushOfs = 1'b1;
        ctl.commit  = 1'b1;
        stateNxt    = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= ctl.commit || ctl.abortFault;
    end
  end

  AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && start) |-> !ctl.capture); // R10

  AST_FAR_SELECTOR_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pushOfs && isFar) |-> $past(ctl.pushSel)); // R5

  AST_PUSH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.capture, ctl.pushSel, ctl.pushOfs, ctl.abortFault})); // R4
endmodule

// File: rtl/call_push_unit.sv
module call_push_unit
  import call_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        callForm,
  input  logic              opSize32,
  input  logic [ADDR_W-1:0] nextIp,
  input  logic [ADDR_W-1:0] operand,
  input  logic [SEL_W-1:0]  farSel,
  input  logic [SEL_W-1:0]  curCs,
  input  logic [ADDR_W-1:0] curEip,
  input  logic [ADDR_W-1:0] curSp,
  input  logic [ADDR_W-1:0] codeLimit,
  input  logic [ADDR_W-1:0] stackLow,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] wrData,
  output logic              wrWide,
  output logic [SEL_W-1:0]  newCs,
  output logic [ADDR_W-1:0] newEip,
  output logic [ADDR_W-1:0] newSp,
  output logic              gpFault,
  output logic              ssFault,
  output logic              done
);
  dpCtl_t ctl;
  logic   isFar, faultAny;

  call_control u_control (
    .clk(clk), .rstN(rstN), .start(start), .isFar(isFar),
    .faultAny(faultAny), .ctl(ctl), .done(done)
  );

  call_datapath #(.AW(ADDR_W), .SW(SEL_W)) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .callForm(callForm),
    .opSize32(opSize32), .nextIp(nextIp), .operand(operand),
    .farSel(farSel), .curCs(curCs), .curEip(curEip), .curSp(curSp),
    .codeLimit(codeLimit), .stackLow(stackLow), .isFar(isFar),
    .faultAny(faultAny), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrWide(wrWide), .newCs(newCs), .newEip(newEip), .newSp(newSp),
    .gpFault(gpFault), .ssFault(ssFault)
  );
endmodule

// File: tb/call_push_unit_bench.sv
module call_push_unit_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  callForm = '0;
  logic        opSize32 = 1'b0;
  logic [31:0] nextIp = '0, operand = '0, curEip = '0, curSp = '0;
  logic [31:0] codeLimit = '0, stackLow = '0;
  logic [15:0] farSel = '0, curCs = '0;
  logic        wrEn, wrWide, gpFault, ssFault, done;
  logic [31:0] wrAddr, wrData, newEip, newSp;
  logic [15:0] newCs;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  call_push_unit u_call_push_unit (
    .clk(clk), .rstN(rstN), .start(start), .callForm(callForm),
    .opSize32(opSize32), .nextIp(nextIp), .operand(operand),
    .farSel(farSel), .curCs(curCs), .curEip(curEip), .curSp(curSp),
    .codeLimit(codeLimit), .stackLow(stackLow), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .wrWide(wrWide), .newCs(newCs),
    .newEip(newEip), .newSp(newSp), .gpFault(gpFault), .ssFault(ssFault),
    .done(done)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Runs one call, computes the expected outcome from the requirements,
  // and compares every write and result. glitch pulses start while busy.
  task automatic doCall(string tag, logic [1:0] form, logic wide,
                        logic [31:0] nip, logic [31:0] opnd, logic [15:0] sel,
                        logic [15:0] cs, logic [31:0] eip, logic [31:0] sp,
                        logic [31:0] clim, logic [31:0] slow, bit glitch);
    logic [31:0] sz, raw, tgt, ret, tot;
    logic [31:0] expA [2];
    logic [31:0] expD [2];
    logic [31:0] gotA [4];
    logic [31:0] gotD [4];
    bit far, gp, ss, flt, seenDone;
    int nExp, nGot, lat, expLat;
    sz  = wide ? 32'd4 : 32'd2;
    far = form[1];
    raw = (form == 2'b00) ? nip + opnd : opnd;
    tgt = wide ? raw : {16'h0, raw[15:0]};
    ret = wide ? nip : {16'h0, nip[15:0]};
    tot = far ? 2 * sz : sz;
    gp  = tgt > clim;
    ss  = {1'b0, sp} < ({1'b0, slow} + {1'b0, tot});
    flt = gp || ss;
    nExp = flt ? 0 : (far ? 2 : 1);
    if (far) begin
      expA[0] = sp - sz;     expD[0] = {16'h0, cs};
      expA[1] = sp - 2 * sz; expD[1] = ret;
    end else begin
      expA[0] = sp - sz;     expD[0] = ret;
      expA[1] = '0;          expD[1] = '0;
    end
    expLat = flt ? 2 : (far ? 4 : 3);

    @(negedge clk);
    callForm = form; opSize32 = wide; nextIp = nip; operand = opnd;
    farSel = sel; curCs = cs; curEip = eip; curSp = sp;
    codeLimit = clim; stackLow = slow; start = 1'b1;
    nGot = 0; lat = 0; seenDone = 0;
    for (int i = 1; i <= 8 && !seenDone; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (glitch && i == 2) begin
        start = 1'b1; operand = ~opnd; curSp = sp ^ 32'h100; farSel = ~sel;
      end
      if (wrEn) begin
        if (nGot < 4) begin gotA[nGot] = wrAddr; gotD[nGot] = wrData; end
        nGot++;
        check(tag, "write width", {31'h0, wrWide}, {31'h0, wide});
      end
      if (done) begin seenDone = 1; lat = i; end
    end
    start = 1'b0;
    check(tag, "done seen", {31'h0, seenDone}, 32'h1);
    check(tag, "R9 done latency", lat, expLat);
    check(tag, "write count", nGot, nExp);
    for (int k = 0; k < nExp && k < nGot; k++) begin
      check(tag, "write address", gotA[k], expA[k]);
      check(tag, "write data", gotD[k], expD[k]);
    end
    check(tag, "newCs", {16'h0, newCs}, flt ? {16'h0, cs} : (far ? {16'h0, sel} : {16'h0, cs}));
    check(tag, "newEip", newEip, flt ? eip : tgt);
    check(tag, "newSp", newSp, flt ? sp : sp - tot);
    check(tag, "gpFault", {31'h0, gpFault}, {31'h0, gp});
    check(tag, "ssFault", {31'h0, ssFault}, {31'h0, ss});
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check(tag, "R9/R10 quiet after done", {30'h0, wrEn, done}, 32'h0);
    end
  endtask

  task automatic testReset();
    check("R11", "done", {31'h0, done}, 32'h0);
    check("R11", "wrEn", {31'h0, wrEn}, 32'h0);
    check("R11", "faults", {30'h0, gpFault, ssFault}, 32'h0);
    check("R11", "newEip", newEip, 32'h0);
    check("R11", "newSp", newSp, 32'h0);
    check("R11", "newCs", {16'h0, newCs}, 32'h0);
  endtask

  task automatic testNear();
    doCall("R1", 2'b00, 1'b1, 32'h1000_0010, 32'hFFFF_FFF0, 16'h0, 16'h0030,
           32'h1000_000B, 32'h0000_8000, 32'hFFFF_FFFF, 32'h0, 0);
    doCall("R2", 2'b00, 1'b0, 32'h0002_FFFE, 32'h0000_0010, 16'h0, 16'h0031,
           32'h0002_FFFB, 32'h0000_0200, 32'h0000_FFFF, 32'h0, 0);
    doCall("R3", 2'b01, 1'b1, 32'h0000_4444, 32'h0012_3456, 16'h0, 16'h0040,
           32'h0000_4440, 32'h0001_0000, 32'h00FF_FFFF, 32'h0, 0);
    doCall("R4", 2'b01, 1'b0, 32'h0001_2222, 32'h0077_0100, 16'h0, 16'h0041,
           32'h0001_2220, 32'h0000_0102, 32'h0000_FFFF, 32'h0000_0100, 0);
  endtask

  task automatic testFar();
    doCall("R5", 2'b10, 1'b0, 32'h0003_0456, 32'hABCD_1234, 16'h2000, 16'h0700,
           32'h0003_0451, 32'h0000_1000, 32'h0000_FFFF, 32'h0, 0);
    doCall("R5", 2'b11, 1'b1, 32'h0040_0010, 32'h0050_0000, 16'h1234, 16'hF00D,
           32'h0040_000A, 32'h0002_0000, 32'h00FF_FFFF, 32'h0001_0000, 0);
  endtask

  task automatic testFaults();
    doCall("R6", 2'b01, 1'b1, 32'h0000_1000, 32'h0000_5000, 16'h0, 16'h0050,
           32'h0000_0FFB, 32'h0000_3000, 32'h0000_4FFF, 32'h0, 0);
    doCall("R6", 2'b01, 1'b1, 32'h0000_1000, 32'h0000_4FFF, 16'h0, 16'h0050,
           32'h0000_0FFB, 32'h0000_3000, 32'h0000_4FFF, 32'h0, 0);
    doCall("R7", 2'b10, 1'b1, 32'h0000_2000, 32'h0000_0100, 16'h0099, 16'h0051,
           32'h0000_1FF9, 32'h0000_0107, 32'h0000_FFFF, 32'h0000_0100, 0);
    doCall("R7", 2'b10, 1'b1, 32'h0000_2000, 32'h0000_0100, 16'h0099, 16'h0051,
           32'h0000_1FF9, 32'h0000_0108, 32'h0000_FFFF, 32'h0000_0100, 0);
    doCall("R8", 2'b00, 1'b1, 32'h0000_3000, 32'h0000_0010, 16'h0, 16'h0052,
           32'h0000_2FFB, 32'h0000_0002, 32'hFFFF_FFFF, 32'h0, 0);
  endtask

  task automatic testBusyStart();
    doCall("R10", 2'b10, 1'b1, 32'h0000_6000, 32'h0000_7000, 16'h0123, 16'h0456,
           32'h0000_5FFB, 32'h0000_9000, 32'hFFFF_FFFF, 32'h0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testNear();
    testFar();
    testFaults();
    testBusyStart();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule